// File: doc/BRIEF.md
# Ethernet MAC Flow Control and Backpressure Unit

This unit sits beside an Ethernet MAC and decides when the MAC should send a pause frame, when the transmitter must hold off because the link partner asked for a pause, and when a half-duplex receiver should jam an incoming frame because its receive buffer is nearly full. It does not build frame bytes, drive the transmit path or hold buffer memory. It only raises requests and tracks the state of received pause frames.

Software controls the unit through one 8-bit control/status register. Two self-clearing command bits each ask for a single pause frame with a fixed pause time: one asks for zero, which resumes the partner, and one asks for 0xFFFF, which stops it. An automatic mode watches the receive fill level against a high mark and a low mark. It asks for one stop frame when the level rises past the high mark and one resume frame when the level falls below the low mark. Each pause request is held until the MAC strobes `pause_done`. A received pause frame loads a down-counter with the pause time multiplied by 2^QSHIFT bit times. While that counter is nonzero and flow control is enabled, the transmitter is inhibited. Two backpressure modes apply in half duplex only: one jams every arriving frame and the other jams only frames whose destination address matches. Both act only while the buffer is above a backpressure mark.

Top module: `flow_ctrl_unit`

## Requirements
- R1: After reset, `reg_rdata` is 0x00, and `pause_req`, `jam_req` and `tx_inhibit` are all low.
- R2: Writing 1 to bit 0 raises `pause_req` with `pause_time` 0x0000 on the next cycle. The request holds until `pause_done`, and bit 0 reads 0 afterwards.
- R3: Writing 1 to bit 1 raises `pause_req` with `pause_time` 0xFFFF. The request holds until `pause_done`, and bit 1 reads 0 afterwards.
- R4: When bits 0 and 1 are both pending, the 0x0000 request is presented first. The 0xFFFF request follows after the first `pause_done`.
- R5: With bit 2 set (automatic mode), `fill_level > hi_mark` while not already above yields exactly one 0xFFFF request. The level staying high yields no further request.
- R6: In automatic mode, after the high crossing, `fill_level < lo_mark` yields exactly one 0x0000 request. A newer automatic request replaces an unserved automatic request of the opposite kind.
- R7: With bit 3 set, in half duplex (`full_duplex`=0), an `rx_sof` while `fill_level > bp_mark` gives a one-cycle `jam_req` on the following cycle, whatever `da_match` is.
- R8: With bit 4 set, in half duplex, `jam_req` follows `rx_sof` only if `da_match` is high and `fill_level > bp_mark`.
- R9: `jam_req` never rises while `full_duplex` is 1, and never rises without a preceding `rx_sof`.
- R10: Bit 5 sets on `rx_pause_vld` and clears on the edge where `reg_rd` is high. If both happen on the same edge, it stays set.
- R11: Bit 6 (read-only) is high while the pause counter is nonzero. `rx_pause_vld` loads the counter with `rx_pause_time` × 2^QSHIFT, and each `bit_tick` decrements it. A pause time of zero leaves bit 6 low.
- R12: `tx_inhibit` is high exactly when bit 7 (flow control enable) is set and bit 6 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (clears bit 5) |
| reg_rdata | output | 8 | Register read data |
| fill_level | input | LVL_W | Receive buffer fill level |
| hi_mark | input | LVL_W | Automatic pause high mark |
| lo_mark | input | LVL_W | Automatic pause low mark |
| bp_mark | input | LVL_W | Backpressure high mark |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| rx_sof | input | 1 | Start of an incoming frame (one cycle) |
| da_match | input | 1 | Destination address of the incoming frame matches |
| rx_pause_vld | input | 1 | A pause frame was received (one cycle) |
| rx_pause_time | input | 16 | Pause time of the received frame |
| bit_tick | input | 1 | One pulse per bit time |
| pause_req | output | 1 | Request to send a pause frame |
| pause_time | output | 16 | Pause time for the requested frame |
| pause_done | input | 1 | MAC finished sending the requested pause frame |
| tx_inhibit | output | 1 | Hold off the transmitter |
| jam_req | output | 1 | Jam the incoming frame (half duplex) |

## Verification
A wrong automatic-threshold state shows at the ports as a missing, doubled or wrong-polarity pause request on the cycle after the level crosses a mark. Sweeping the level up and down, and counting requests by kind, reveals it within one ramp. A wrong pause counter shows as `tx_inhibit` or bit 6 dropping one tick early or late. The bench checks every tick of several countdowns. Jam decoding errors appear on the single cycle after `rx_sof`, so all 32 combinations of duplex, mode, address match and level are tried one at a time.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int B_XON     = 0;
  localparam int B_XOFF    = 1;
  localparam int B_AUTO    = 2;
  localparam int B_BPANY   = 3;
  localparam int B_BPMATCH = 4;
  localparam int B_SEEN    = 5;
  localparam int B_ACT     = 6;
  localparam int B_FCEN    = 7;

  localparam logic [15:0] T_XON  = 16'h0000;
  localparam logic [15:0] T_XOFF = 16'hFFFF;

  typedef struct packed {
    logic fc_en;
    logic bp_match;
    logic bp_any;
    logic auto_en;
    logic cmd_xoff;
    logic cmd_xon;
  } fc_ctrl_t;
endpackage

// File: rtl/fc_ctrl_reg.sv
module fc_ctrl_reg
  import fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       rd,
  input  logic       done_xon,
  input  logic       done_xoff,
  input  logic       seen_set,
  input  logic       active,
  output fc_ctrl_t   ctrl,
  output logic [7:0] rdata
);
  fc_ctrl_t ctrl_q, ctrl_d;
  logic     seen_q, seen_d;
  logic     unused_w;

  assign unused_w = ^wdata[B_ACT:B_SEEN];

  always_comb begin
    ctrl_d = ctrl_q;
    seen_d = seen_q;
    if (done_xon)  ctrl_d.cmd_xon  = 1'b0;
    if (done_xoff) ctrl_d.cmd_xoff = 1'b0;
    if (wr) begin
      ctrl_d.cmd_xon  = wdata[B_XON];
      ctrl_d.cmd_xoff = wdata[B_XOFF];
      ctrl_d.auto_en  = wdata[B_AUTO];
      ctrl_d.bp_any   = wdata[B_BPANY];
      ctrl_d.bp_match = wdata[B_BPMATCH];
      ctrl_d.fc_en    = wdata[B_FCEN];
    end
    if (rd)       seen_d = 1'b0;
    if (seen_set) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      seen_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      seen_q <= seen_d;
    end
  end

  assign ctrl = ctrl_q;

  always_comb begin
    rdata            = '0;
    rdata[B_XON]     = ctrl_q.cmd_xon;
    rdata[B_XOFF]    = ctrl_q.cmd_xoff;
    rdata[B_AUTO]    = ctrl_q.auto_en;
    rdata[B_BPANY]   = ctrl_q.bp_any;
    rdata[B_BPMATCH] = ctrl_q.bp_match;
    rdata[B_SEEN]    = seen_q;
    rdata[B_ACT]     = active;
    rdata[B_FCEN]    = ctrl_q.fc_en;
  end
endmodule

// File: rtl/fc_pause_gen.sv
module fc_pause_gen
  import fc_pkg::*;
#(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             cmd_xon,
  input  logic             cmd_xoff,
  input  logic [LVL_W-1:0] fill,
  input  logic [LVL_W-1:0] hi,
  input  logic [LVL_W-1:0] lo,
  input  logic             pause_done,
  output logic             pause_req,
  output logic [15:0]      pause_time,
  output logic             done_xon,
  output logic             done_xoff
);
  logic above_q, above_d;
  logic axon_q, axon_d;
  logic axoff_q, axoff_d;
  logic want_xon, want_xoff;

  assign want_xon   = cmd_xon | axon_q;
  assign want_xoff  = cmd_xoff | axoff_q;
  assign pause_req  = want_xon | want_xoff;
  assign pause_time = want_xon ? T_XON : T_XOFF;
  assign done_xon   = pause_done & want_xon;
  assign done_xoff  = pause_done & ~want_xon & want_xoff;

  always_comb begin
    above_d = above_q;
    axon_d  = axon_q & ~done_xon;
    axoff_d = axoff_q & ~done_xoff;
    if (auto_en) begin
      if (!above_q && (fill > hi)) begin
        above_d = 1'b1;
        axoff_d = 1'b1;
        axon_d  = 1'b0;
      end else if (above_q && (fill < lo)) begin
        above_d = 1'b0;
        axon_d  = 1'b1;
        axoff_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      axon_q  <= 1'b0;
      axoff_q <= 1'b0;
    end else begin
      above_q <= above_d;
      axon_q  <= axon_d;
      axoff_q <= axoff_d;
    end
  end
endmodule

// File: rtl/fc_rx_pause.sv
module fc_rx_pause #(
  parameter int QSHIFT = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] ptime,
  input  logic        tick,
  output logic        active
);
  localparam int CNT_W = 16 + QSHIFT;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign active = (cnt_q != '0);
  assign cnt_en = load | (tick & active);

  always_comb begin
    if (load) cnt_d = {ptime, {QSHIFT{1'b0}}};
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fc_jam.sv
module fc_jam #(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_duplex,
  input  logic             rx_sof,
  input  logic             da_match,
  input  logic [LVL_W-1:0] fill,
  input  logic [LVL_W-1:0] bp_mark,
  input  logic             bp_any,
  input  logic             bp_match,
  output logic             jam_req
);
  logic jam_q, jam_d;

  always_comb begin
    jam_d = rx_sof & ~full_duplex & (fill > bp_mark)
          & (bp_any | (bp_match & da_match));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) jam_q <= 1'b0;
    else        jam_q <= jam_d;
  end

  assign jam_req = jam_q;
endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
  import fc_pkg::*;
#(
  parameter int LVL_W  = 12,
  parameter int QSHIFT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  input  logic             reg_rd,
  output logic [7:0]       reg_rdata,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] hi_mark,
  input  logic [LVL_W-1:0] lo_mark,
  input  logic [LVL_W-1:0] bp_mark,
  input  logic             full_duplex,
  input  logic             rx_sof,
  input  logic             da_match,
  input  logic             rx_pause_vld,
  input  logic [15:0]      rx_pause_time,
  input  logic             bit_tick,
  output logic             pause_req,
  output logic [15:0]      pause_time,
  input  logic             pause_done,
  output logic             tx_inhibit,
  output logic             jam_req
);
  fc_ctrl_t ctrl;
  logic     done_xon, done_xoff, active;

  fc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .rd(reg_rd),
    .done_xon(done_xon), .done_xoff(done_xoff), .seen_set(rx_pause_vld),
    .active(active), .ctrl(ctrl), .rdata(reg_rdata)
  );

  fc_pause_gen #(.LVL_W(LVL_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .auto_en(ctrl.auto_en),
    .cmd_xon(ctrl.cmd_xon), .cmd_xoff(ctrl.cmd_xoff),
    .fill(fill_level), .hi(hi_mark), .lo(lo_mark), .pause_done(pause_done),
    .pause_req(pause_req), .pause_time(pause_time),
    .done_xon(done_xon), .done_xoff(done_xoff)
  );

  fc_rx_pause #(.QSHIFT(QSHIFT)) u_rxp (
    .clk(clk), .rst_n(rst_n), .load(rx_pause_vld), .ptime(rx_pause_time),
    .tick(bit_tick), .active(active)
  );

  fc_jam #(.LVL_W(LVL_W)) u_jam (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .rx_sof(rx_sof),
    .da_match(da_match), .fill(fill_level), .bp_mark(bp_mark),
    .bp_any(ctrl.bp_any), .bp_match(ctrl.bp_match), .jam_req(jam_req)
  );

  assign tx_inhibit = ctrl.fc_en & active;
endmodule

// File: rtl/flow_ctrl_chk.sv
module flow_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_rdata,
  input logic        full_duplex,
  input logic        rx_sof,
  input logic        rx_pause_vld,
  input logic [15:0] rx_pause_time,
  input logic        pause_req,
  input logic        pause_done,
  input logic        tx_inhibit,
  input logic        jam_req
);
  // R9
  jam_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jam_req |-> $past(!full_duplex));
  // R9
  jam_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jam_req |-> $past(rx_sof));
  // R7
  jam_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jam_req && !rx_sof |=> !jam_req);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req && !pause_done && !reg_wr |=> pause_req);
  // R10
  seen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pause_vld |=> reg_rdata[5]);
  // R11
  active_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pause_vld && (rx_pause_time != 16'h0) |=> reg_rdata[6]);
  // R12
  inhibit_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> (reg_rdata[7] && reg_rdata[6]));
endmodule

bind flow_ctrl_unit flow_ctrl_chk u_chk (.*);

// File: tb/flow_ctrl_unit_bench.sv
module flow_ctrl_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;
  localparam int QS = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd;
  logic [7:0]    reg_wdata, reg_rdata;
  logic [LW-1:0] fill_level, hi_mark, lo_mark, bp_mark;
  logic          full_duplex, rx_sof, da_match, rx_pause_vld, bit_tick;
  logic [15:0]   rx_pause_time, pause_time;
  logic          pause_req, pause_done, tx_inhibit, jam_req;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_ctrl_unit #(.LVL_W(LW), .QSHIFT(QS)) u_flow_ctrl_unit (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic ack();
    pause_done = 1'b1;
    step();
    pause_done = 1'b0;
  endtask

  task automatic load_pause(input logic [15:0] t);
    rx_pause_vld = 1'b1; rx_pause_time = t;
    step();
    rx_pause_vld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nxoff, nxon;
    logic [15:0] first_t;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    fill_level = 0; hi_mark = 8'd100; lo_mark = 8'd50; bp_mark = 8'd100;
    full_duplex = 0; rx_sof = 0; da_match = 0; rx_pause_vld = 0;
    rx_pause_time = 0; bit_tick = 1; pause_done = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 pause_req", pause_req, 0);
    chk("R1 jam_req", jam_req, 0);
    chk("R1 tx_inhibit", tx_inhibit, 0);

    // R2 one-shot resume
    wr_reg(8'h01);
    chk("R2 req", pause_req, 1);
    chk("R2 time", pause_time, 16'h0000);
    repeat (3) step();
    chk("R2 held", pause_req, 1);
    ack();
    chk("R2 cleared req", pause_req, 0);
    chk("R2 bit0", reg_rdata[0], 0);

    // R3 one-shot stop
    wr_reg(8'h02);
    chk("R3 req", pause_req, 1);
    chk("R3 time", pause_time, 16'hFFFF);
    repeat (2) step();
    chk("R3 held", pause_req, 1);
    ack();
    chk("R3 cleared req", pause_req, 0);
    chk("R3 bit1", reg_rdata[1], 0);

    // R4 both pending
    wr_reg(8'h03);
    chk("R4 first time", pause_time, 16'h0000);
    ack();
    chk("R4 second req", pause_req, 1);
    chk("R4 second time", pause_time, 16'hFFFF);
    chk("R4 rdata", reg_rdata, 8'h02);
    ack();
    chk("R4 none left", pause_req, 0);

    // R5 R6 automatic sweep: up, down, up
    wr_reg(8'h04);
    nxoff = 0; nxon = 0; first_t = 16'h1234;
    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i <= 50; i++) begin
        fill_level = (pass == 1) ? LW'(250 - 5*i) : LW'(5*i);
        step();
        if (pause_req) begin
          if (first_t == 16'h1234) first_t = pause_time;
          if (pause_time == 16'hFFFF) nxoff++; else nxon++;
          ack();
        end
      end
    end
    chk("R5 stop count", nxoff, 2);
    chk("R6 resume count", nxon, 1);
    chk("R5 first is stop", first_t, 16'hFFFF);
    // R6 newer request replaces unserved opposite
    fill_level = 8'd10; step();
    chk("R6 resume req", pause_time, 16'h0000);
    ack();
    fill_level = 8'd200; step();
    chk("R5 stop pending", pause_time, 16'hFFFF);
    fill_level = 8'd10; step();
    chk("R6 replaced time", pause_time, 16'h0000);
    ack();
    step();
    chk("R6 no stale stop", pause_req, 0);
    wr_reg(8'h00);

    // R7 R8 R9 exhaustive jam sweep
    for (int c = 0; c < 32; c++) begin
      logic fd, any, mt, dm, hi;
      logic exp;
      {fd, any, mt, dm, hi} = 5'(c);
      wr_reg({3'b0, mt, any, 3'b0});
      full_duplex = fd; da_match = dm;
      fill_level = hi ? 8'd200 : 8'd10;
      rx_sof = 1'b1;
      step();
      rx_sof = 1'b0;
      exp = !fd && hi && (any || (mt && dm));
      chk(fd ? "R9 jam" : (any ? "R7 jam" : "R8 jam"), jam_req, exp);
      step();
      chk("R7 jam one cycle", jam_req, 0);
    end
    full_duplex = 0; da_match = 0; fill_level = 0;

    // R10 R11 R12 received pause countdowns
    wr_reg(8'h80);
    for (int t = 1; t <= 5; t += 2) begin
      load_pause(16'(t));
      chk("R10 seen", reg_rdata[5], 1);
      chk("R12 inhibit", tx_inhibit, 1);
      for (int k = 1; k <= (t << QS); k++) begin
        step();
        chk("R11 active", reg_rdata[6], ((t << QS) - k) != 0);
      end
      chk("R12 inhibit off", tx_inhibit, 0);
    end
    // R11 tick gating
    bit_tick = 0;
    load_pause(16'd1);
    repeat (10) step();
    chk("R11 no tick hold", reg_rdata[6], 1);
    bit_tick = 1;
    repeat (4) step();
    chk("R11 end after ticks", reg_rdata[6], 0);
    // R10 read clears
    reg_rd = 1'b1;
    #1;
    chk("R10 read shows", reg_rdata[5], 1);
    step();
    reg_rd = 1'b0;
    chk("R10 read clear", reg_rdata[5], 0);
    // R10 set wins
    reg_rd = 1'b1;
    load_pause(16'd0);
    reg_rd = 1'b0;
    chk("R10 set wins", reg_rdata[5], 1);
    chk("R11 zero time", reg_rdata[6], 0);
    // R12 enable off
    wr_reg(8'h00);
    load_pause(16'd3);
    chk("R12 active", reg_rdata[6], 1);
    chk("R12 no inhibit", tx_inhibit, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule